// File: doc/BRIEF.md
# Sign-Folded Phase Accumulator Oscillator

This block is a numerically controlled oscillator. A 16-bit control word selects a phase increment. While the block runs, a 16-bit phase register advances by that increment on every reference clock. The top bit of the phase register is the square-wave output, so the output frequency is the increment divided by 2^16, times the reference clock frequency. With a 27 MHz reference, a word of 0x8000 gives 13.5 MHz.

Words below half scale are used as they are. A word at or above half scale is folded to its 16-bit two's complement before use. Only a power-of-two increment gives an exact 50% duty cycle. Downstream dividers are meant to see words from 1 to 32768.

The word is loaded through two byte-wide write ports. An upper-byte write is only staged. A lower-byte write commits the whole word at once. A one-cycle tick marks every rising edge of the output, and a downstream divider uses it as a clock enable.

Top module: `nco_tick_gen`

## Requirements
- R1: After a synchronous active-low reset, the active word is 0x0000, the staged upper byte is 0x00, and both wave_out and tick are low.
- R2: A write to the upper byte alone is held in a staging register. It leaves the active increment, and so the output waveform, unchanged.
- R3: A write to the lower byte loads the active word as {staged upper byte, written lower byte} in one step. The new increment is first added on the clock edge after the write.
- R4: With word bit 15 clear, the increment equals the word. With bit 15 set, the increment is (2^16 - word) mod 2^16, so 0x8000 gives 0x8000 and 0xFFFF gives 1.
- R5: While running with a nonzero increment W, the 16-bit phase register advances by W modulo 2^16 on each clock. wave_out is phase bit 15, so across 65536 cycles from phase zero the output rises exactly W times.
- R6: For a power-of-two increment W, over P = 65536/W cycles starting from phase zero, wave_out is high for exactly P/2 cycles.
- R7: tick is high for exactly one cycle on each cycle where wave_out has just gone from 0 to 1, and it is low at all other times.
- R8: With run low, the phase register is cleared on the next edge and stays cleared. wave_out and tick stay low.
- R9: An increment of zero behaves like run low: the output stays low and no ticks are produced.
- R10: When both bytes are written in the same cycle, the committed word uses the upper byte written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_wr_en | input | 1 | Upper-byte write strobe (stages the byte only) |
| hi_wr_data | input | 8 | Upper byte of the control word |
| lo_wr_en | input | 1 | Lower-byte write strobe (commits the whole word) |
| lo_wr_data | input | 8 | Lower byte of the control word |
| run | input | 1 | Run enable; low clears the phase |
| wave_out | output | 1 | Square-wave output (phase MSB) |
| tick | output | 1 | One-cycle pulse on each rising edge of wave_out |

## Verification
The hardest case to reach from the ports is a word change in the middle of a run. The new word must be staged and committed with no cycle in which a half-old, half-new increment is used. The stimulus stages a new upper byte during a long run and measures a full period to show the rate is unchanged. It then commits the lower byte and compares every cycle against an arithmetic phase model. Exact duty and tick counts are checked over full periods, starting from a cleared phase, for every power-of-two word from 4 to 0x8000 and for several folded words.

// File: rtl/nco_pkg.sv
// Shared types for the phase accumulator oscillator.
// Assumes: consumers import the package; no state is held here.
package nco_pkg;
    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_STEP = 1'b1
    } phase_mode_e;
endpackage

// File: rtl/nco_word_stage.sv
// Holds the staged upper byte and the active control word, and folds the word
// into the phase increment.
// Assumes: the upper byte is written before (or together with) the lower byte;
// only a lower-byte write changes the active word.
module nco_word_stage #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hi_wr_en,
    input  logic [WORD_W-BYTE_W-1:0] hi_wr_data,
    input  logic                     lo_wr_en,
    input  logic [BYTE_W-1:0]        lo_wr_data,
    output logic [WORD_W-1:0]        incr
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic [HI_W-1:0]   hi_stage;
    logic [HI_W-1:0]   hi_merge;
    logic [WORD_W-1:0] act_word;

    // Purpose: capture the upper byte without touching the active word.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_stage <= '0;
        else if (hi_wr_en) hi_stage <= hi_wr_data;
    end

    // Purpose: pick the upper byte being written this cycle if there is one.
    always_comb begin
        hi_merge = hi_wr_en ? hi_wr_data : hi_stage;
    end

    // Purpose: commit the full word in one step on a lower-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_word <= '0;
        else if (lo_wr_en) act_word <= {hi_merge, lo_wr_data};
    end

    // Purpose: sign-fold words at or above half scale to their two's complement.
    always_comb begin
        if (act_word[WORD_W-1]) incr = ~act_word + WORD_W'(1);
        else                    incr = act_word;
    end

    // R2: an upper-byte-only write leaves the active word unchanged
    p_hi_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_en && !lo_wr_en) |=> $stable(act_word));

    // R3: the lower half of the active word is the byte just written
    p_lo_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_en |=> (act_word[BYTE_W-1:0] == $past(lo_wr_data)));

    // R4: word plus folded increment wraps to zero whenever the top bit is set
    p_fold_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_word[WORD_W-1] |-> (WORD_W'(act_word + incr) == '0));
endmodule

// File: rtl/nco_phase_acc.sv
// Phase register that advances by the increment each clock while running.
// Assumes: the increment is stable for the cycle; zero increment counts as idle.
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] incr,
    output logic              phase_msb
);
    phase_mode_e       mode;
    logic [WORD_W-1:0] phase;

    // Purpose: decide whether the phase steps or is held cleared.
    always_comb begin
        mode = (run && (incr != '0)) ? PH_STEP : PH_HOLD;
    end

    // Purpose: advance the phase modulo 2^WORD_W, or clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (mode == PH_STEP) phase <= phase + incr;
        else                      phase <= '0;
    end

    assign phase_msb = phase[WORD_W-1];

    // R8: run low clears the phase on the next edge
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase == '0));

    // R9: a zero increment clears the phase on the next edge
    p_zero_incr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (incr == '0) |=> (phase == '0));
endmodule

// File: rtl/nco_edge_tick.sv
// Produces a one-cycle pulse on each 0-to-1 transition of the wave.
// Assumes: the wave comes straight from a register clocked by clk.
module nco_edge_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic wave,
    output logic tick
);
    logic wave_q;

    // Purpose: remember the previous wave level.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave;
    end

    // Purpose: flag the first high cycle of each high phase.
    always_comb begin
        tick = wave & ~wave_q;
    end
endmodule

// File: rtl/nco_tick_gen.sv
// Top level of the sign-folded phase accumulator oscillator: word staging,
// phase accumulation and rising-edge tick.
// Assumes: one reference clock domain and synchronous active-low reset.
module nco_tick_gen #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hi_wr_en,
    input  logic [WORD_W-BYTE_W-1:0] hi_wr_data,
    input  logic                     lo_wr_en,
    input  logic [BYTE_W-1:0]        lo_wr_data,
    input  logic                     run,
    output logic                     wave_out,
    output logic                     tick
);
    logic [WORD_W-1:0] incr;

    nco_word_stage #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_wr_en   (hi_wr_en),
        .hi_wr_data (hi_wr_data),
        .lo_wr_en   (lo_wr_en),
        .lo_wr_data (lo_wr_data),
        .incr       (incr)
    );

    nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .incr      (incr),
        .phase_msb (wave_out)
    );

    nco_edge_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .wave  (wave_out),
        .tick  (tick)
    );

    // R7: a tick only appears while the output is high
    p_tick_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> wave_out);

    // R7: a tick never lasts two cycles
    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: run low forces the output low on the next edge
    p_wave_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!wave_out && !tick));
endmodule

// File: tb/nco_tick_gen_test.sv
`timescale 1ns/1ps
module nco_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_wr_en = 1'b0;
    logic [7:0] hi_wr_data = '0;
    logic       lo_wr_en = 1'b0;
    logic [7:0] lo_wr_data = '0;
    logic       run = 1'b0;
    logic       wave_out;
    logic       tick;

    int total = 0;
    int bad = 0;
    int mism = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nco_tick_gen uut (
        .clk(clk), .rst_n(rst_n),
        .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
        .run(run), .wave_out(wave_out), .tick(tick)
    );

    // Arithmetic reference: staged byte, committed word, phase and previous level.
    logic [7:0]  m_hi;
    logic [15:0] m_word, m_acc, m_w;
    logic        m_prev;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = '0; m_word = '0; m_acc = '0; m_prev = 1'b0;
        end else begin
            m_w = m_word[15] ? 16'(17'h10000 - {1'b0, m_word}) : m_word;
            m_prev = m_acc[15];
            if (!run || m_w == 0) m_acc = '0;
            else                  m_acc = m_acc + m_w;
            if (lo_wr_en) m_word = {(hi_wr_en ? hi_wr_data : m_hi), lo_wr_data};
            if (hi_wr_en) m_hi = hi_wr_data;
        end
    end

    // Per-cycle comparison against the reference, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wave_out !== m_acc[15] || tick !== (m_acc[15] & ~m_prev)) mism++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_hi(input logic [7:0] b);
        hi_wr_en = 1'b1; hi_wr_data = b;
        @(negedge clk);
        hi_wr_en = 1'b0;
    endtask

    task automatic wr_lo(input logic [7:0] b);
        lo_wr_en = 1'b1; lo_wr_data = b;
        @(negedge clk);
        lo_wr_en = 1'b0;
    endtask

    task automatic window(input int n, output int highs, output int ticks);
        highs = 0; ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            highs += int'(wave_out);
            ticks += int'(tick);
        end
    endtask

    // Load a word with the phase cleared, then start from phase zero.
    task automatic load_start(input logic [15:0] w);
        run = 1'b0;
        wr_hi(w[15:8]);
        wr_lo(w[7:0]);
        @(negedge clk);
        run = 1'b1;
    endtask

    function automatic int folded(input logic [15:0] w);
        return w[15] ? (65536 - int'(w)) : int'(w);
    endfunction

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h, t, p;
        logic [15:0] fw [4];
        fw = '{16'hC000, 16'hF000, 16'hFFF0, 16'h8000};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 wave after reset", int'(wave_out), 0);
        check("R1 tick after reset", int'(tick), 0);
        rst_n = 1'b1;
        run = 1'b1;
        window(8, h, t);
        check("R1 idle word after reset, highs", h, 0);

        // R6 and R7: power-of-two sweep, exact duty and one tick per period
        for (int k = 2; k < 16; k++) begin
            p = 65536 >> k;
            load_start(16'(1 << k));
            window(p, h, t);
            check($sformatf("R6 duty word 2^%0d", k), h, p / 2);
            check($sformatf("R7 ticks word 2^%0d", k), t, 1);
        end

        // R4: folded words
        foreach (fw[i]) begin
            p = 65536 / folded(fw[i]);
            load_start(fw[i]);
            window(p, h, t);
            check($sformatf("R4 duty folded word %h", fw[i]), h, p / 2);
            check($sformatf("R4 ticks folded word %h", fw[i]), t, 1);
        end

        // R5: non-power-of-two rate over a full phase cycle
        load_start(16'h0003);
        window(65536, h, t);
        check("R5 rises over 65536 cycles, W=3", t, 3);
        load_start(16'hFFFD);
        window(65536, h, t);
        check("R5 rises folded 0xFFFD", t, 3);

        // R2: staging the upper byte mid-run keeps the rate
        load_start(16'h0100);
        window(256, h, t);
        wr_hi(8'h40);
        window(256, h, t);
        check("R2 ticks after upper-only write", t, 1);
        check("R2 duty after upper-only write", h, 128);

        // R3: lower byte commits {0x40, 0x00}; rate becomes 1/4 of the clock
        wr_lo(8'h00);
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        window(4, h, t);
        check("R3 committed word ticks", t, 1);
        check("R3 committed word duty", h, 2);

        // R10: both bytes in one cycle
        run = 1'b0;
        hi_wr_en = 1'b1; hi_wr_data = 8'h20;
        lo_wr_en = 1'b1; lo_wr_data = 8'h00;
        @(negedge clk);
        hi_wr_en = 1'b0; lo_wr_en = 1'b0;
        run = 1'b1;
        window(8, h, t);
        check("R10 same-cycle write ticks", t, 1);
        check("R10 same-cycle write duty", h, 4);

        // R8: run low clears and holds the output low
        load_start(16'h8000);
        window(3, h, t);
        run = 1'b0;
        window(20, h, t);
        check("R8 highs with run low", h, 0);
        check("R8 ticks with run low", t, 0);

        // R9: zero word with run high
        load_start(16'h0000);
        window(50, h, t);
        check("R9 highs with zero word", h, 0);
        check("R9 ticks with zero word", t, 0);

        // R3 and R5: cycle-exact agreement with the reference, including word changes
        check("R5 per-cycle mismatches", mism, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule